// File: doc/BRIEF.md
# Multi-Channel Interrupt Summary Word

This block gathers the interrupt causes of four serial channels, plus three device-wide causes (wake-up, timer/counter and general-purpose I/O pins), into a single 32-bit read-only status word. Software can read one DWORD and learn two things. First, which channels need service, from a pending bitmap. Second, the most urgent cause of each channel, from a packed 3-bit code per channel. Device-wide causes are folded into channel 0 only.

Each cause is held in a sticky flag register. A set strobe raises the flag. A clear strobe, issued by the bus logic when the register that owns the cause is read, lowers it. The status word is a purely combinational function of those flags, so it changes in the cycle after a strobe. The serial channels and the bus decoder are outside this block.

Top module: `irq_summary_word`

## Requirements
- R1: After reset every flag is clear and the status word reads 0x00000000.
- R2: Bit i (i = 0..3) of the word is 1 exactly when channel i has any pending cause; for channel 0, pending device-wide causes also count.
- R3: Bits [7:4] and bits [31:20] always read as zero.
- R4: The code of channel i sits at bits [8+3i+2 : 8+3i]. The channel causes are encoded as follows: receive line error = 3'b100, receive data = 3'b011, transmit/modem = 3'b010. Among these, line error outranks receive data, which outranks transmit/modem.
- R5: A channel with nothing pending shows code 3'b000.
- R6: The device-wide codes are timer = 3'b111, I/O pins = 3'b110 and wake-up = 3'b001. They appear only in channel 0's field; the fields of channels 1 to 3 never show them.
- R7: In channel 0's field, any pending channel cause outranks the device-wide causes. Among the device-wide causes, timer outranks I/O pins, which outranks wake-up.
- R8: Code 3'b101 never appears in any field.
- R9: A set strobe at a clock edge makes its cause visible in the word after that edge. The cause stays pending, unchanged, until it is cleared.
- R10: A clear strobe removes only its own cause. If set and clear for the same cause arrive at the same edge, the set wins.

Strobe bit layout. Channel causes use `chan_set`/`chan_clr` bit 3i+0 for transmit/modem, 3i+1 for receive data and 3i+2 for line error. Device-wide causes use `dev_set`/`dev_clr` bit 0 for wake-up, bit 1 for I/O pins and bit 2 for timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_set | input | 12 | Per-channel cause set strobes |
| chan_clr | input | 12 | Per-channel cause clear strobes |
| dev_set | input | 3 | Device-wide cause set strobes |
| dev_clr | input | 3 | Device-wide cause clear strobes |
| status | output | 32 | Summary word |

## Verification
Channel 0 is swept over all 64 combinations of its three channel causes and three device-wide causes. This sweep separates the priority of channel causes over device-wide ones, and the internal ordering of each group. Channels 1 to 3 are each swept over their eight combinations while every device-wide cause is pending, which shows that global codes never leak into those fields. A long run of mixed patterns across all fifteen causes checks that the fields do not interfere with one another. Incremental set, selective clear, hold and simultaneous set-and-clear sequences separate the sticky behaviour from a simple pass-through.

// File: rtl/irq_summary_word.sv
module irq_summary_word #(
  parameter int NUM_CH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH*3-1:0] chan_set,
  input  logic [NUM_CH*3-1:0] chan_clr,
  input  logic [2:0]          dev_set,
  input  logic [2:0]          dev_clr,
  output logic [31:0]         status
);
  localparam int CW = NUM_CH * 3;
  localparam int FIELD_LO = 8;

  logic [CW-1:0] chan_q;
  logic [2:0]    dev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_q <= '0;
      dev_q  <= '0;
    end else begin
      chan_q <= (chan_q & ~chan_clr) | chan_set;
      dev_q  <= (dev_q & ~dev_clr) | dev_set;
    end
  end

  function automatic logic [2:0] pick(input logic [2:0] f, input logic [2:0] g);
    if (f[2])      pick = 3'b100;
    else if (f[1]) pick = 3'b011;
    else if (f[0]) pick = 3'b010;
    else if (g[2]) pick = 3'b111;
    else if (g[1]) pick = 3'b110;
    else if (g[0]) pick = 3'b001;
    else           pick = 3'b000;
  endfunction

  always_comb begin
    status = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      status[i] = |chan_q[3*i +: 3] | ((i == 0) ? |dev_q : 1'b0);
      status[FIELD_LO + 3*i +: 3] = pick(chan_q[3*i +: 3], (i == 0) ? dev_q : 3'b000);
    end
  end

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[31:FIELD_LO+CW] == '0 && status[7:NUM_CH] == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R2
    pend_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[i] == (status[FIELD_LO+3*i +: 3] != 3'b000));
    // R8
    no_reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[FIELD_LO+3*i +: 3] != 3'b101);
    // R9
    set_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |chan_set[3*i +: 3] |=> status[i]);
    if (i == 0) begin : g_c0
      // R10
      clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&chan_clr[2:0] && &dev_clr && chan_set[2:0] == 3'b000 && dev_set == 3'b000) |=> !status[0]);
    end else begin : g_cn
      // R6
      no_global_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[FIELD_LO+3*i +: 3] != 3'b111 && status[FIELD_LO+3*i +: 3] != 3'b110 &&
        status[FIELD_LO+3*i +: 3] != 3'b001);
      // R10
      clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&chan_clr[3*i +: 3] && chan_set[3*i +: 3] == 3'b000) |=> !status[i]);
    end
  end
endmodule

// File: tb/irq_summary_word_test.sv
module irq_summary_word_test;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] chan_set = '0, chan_clr = '0;
  logic [2:0]  dev_set = '0, dev_clr = '0;
  logic [31:0] status;

  int vectors = 0, errors = 0;
  logic [11:0] m_c = '0;
  logic [2:0]  m_g = '0;
  bit done = 0;

  irq_summary_word uut (.clk(clk), .rst_n(rst_n), .chan_set(chan_set), .chan_clr(chan_clr),
                        .dev_set(dev_set), .dev_clr(dev_clr), .status(status));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_word(input logic [11:0] c, input logic [2:0] g);
    logic [31:0] w = '0;
    for (int ch = 0; ch < 4; ch++) begin
      logic [2:0] f = c[3*ch +: 3];
      logic [2:0] code = 3'd0;
      if (ch == 0) begin
        if (g[0]) code = 3'd1;
        if (g[1]) code = 3'd6;
        if (g[2]) code = 3'd7;
      end
      if (f[0]) code = 3'd2;
      if (f[1]) code = 3'd3;
      if (f[2]) code = 3'd4;
      w[ch] = (f != 0) || (ch == 0 && g != 0);
      w[8 + 3*ch +: 3] = code;
    end
    return w;
  endfunction

  task automatic check(input string tag);
    logic [31:0] e = exp_word(m_c, m_g);
    vectors++;
    if (status !== e) begin
      errors++;
      $display("FAIL %s: status=%08h expected=%08h", tag, status, e);
    end
  endtask

  task automatic step(input logic [11:0] cs, input logic [11:0] cc,
                      input logic [2:0] gs, input logic [2:0] gc, input string tag);
    chan_set = cs; chan_clr = cc; dev_set = gs; dev_clr = gc;
    @(negedge clk);
    chan_set = '0; chan_clr = '0; dev_set = '0; dev_clr = '0;
    m_c = (m_c & ~cc) | cs;
    m_g = (m_g & ~gc) | gs;
    check(tag);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (status !== 32'h0) begin
      errors++;
      $display("FAIL R1 reset: status=%08h expected=00000000", status);
    end
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset release");

    // R7 / R4 / R5: channel 0 exhaustive
    for (int g = 0; g < 8; g++)
      for (int f = 0; f < 8; f++)
        step({9'd0, 3'(f)}, 12'hFFF, 3'(g), 3'h7, "R7 ch0 sweep");

    // R6 / R4: channels 1..3 with all globals pending
    for (int ch = 1; ch < 4; ch++)
      for (int f = 0; f < 8; f++)
        step(12'(f) << (3*ch), 12'hFFF, 3'h7, 3'h7, "R6 chN sweep");

    // R2 / R3 / R8: mixed patterns
    for (int k = 0; k < 256; k++) begin
      logic [14:0] p = 15'(k * 173 + 29);
      step(p[11:0], 12'hFFF, p[14:12], 3'h7, "R2 mixed");
      vectors++;
      if (status[31:20] !== 0 || status[7:4] !== 0) begin
        errors++;
        $display("FAIL R3 reserved bits: status=%08h expected upper/mid zero", status);
      end
      for (int ch = 0; ch < 4; ch++) begin
        vectors++;
        if (status[8+3*ch +: 3] === 3'b101) begin
          errors++;
          $display("FAIL R8 code 101 ch%0d: status=%08h expected no 101", ch, status);
        end
      end
    end

    // R9: accumulate without clearing, then hold
    step('0, 12'hFFF, '0, 3'h7, "R5 all clear");
    step(12'h001, '0, '0, '0, "R9 set tx ch0");
    step('0, '0, 3'h1, '0, "R9 set wake");
    step(12'h040, '0, '0, '0, "R9 set tx ch2");
    step(12'h800, '0, 3'h4, '0, "R9 set line ch3 + timer");
    for (int n = 0; n < 4; n++) step('0, '0, '0, '0, "R9 hold");

    // R10: selective clear and set-wins
    step('0, 12'h001, '0, '0, "R10 clear tx ch0");
    step('0, '0, '0, 3'h4, "R10 clear timer");
    step(12'h040, 12'h040, '0, '0, "R10 set wins ch2");
    step('0, '0, 3'h1, 3'h1, "R10 set wins wake");
    step('0, 12'h800, '0, '0, "R10 clear line ch3");
    step('0, 12'h040, '0, 3'h1, "R10 clear rest");
    vectors++;
    if (status !== 32'h0) begin
      errors++;
      $display("FAIL R10 final: status=%08h expected=00000000", status);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule